// File: doc/BRIEF.md
# Channel Control Register

This block holds the per-channel register state of a descriptor-driven DMA channel and decides how the channel state changes when software writes to it. It is reached through a 32-bit, word-only register port with a small word index. It keeps a 16-bit status word, a command pointer and three condition-select registers. It tells the descriptor sequencer, through single-cycle pulses, when to start, when to fetch a descriptor and when the attached peripheral must flush.

A control write does not overwrite the status word. Its upper half acts as a per-bit enable and its lower half supplies the new values, so software can set or clear any subset of the writable bits in one access. After the merge, the block applies the channel rules. Wake and run bring the channel alive, run also clears the dead flag, pause takes precedence over both, and dropping run shuts the channel down. A flush that ends up set is turned into a pulse and is never left in the stored status.

Top module: `chan_ctrl_regs`

Word index map: 0 control, 1 status, 2 command pointer, 3 interrupt select, 4 branch select, 5 wait select, 6 and 7 unused.

## Requirements
- R1: After reset the status word, the command pointer and the select registers are zero, and the flush, start and fetch pulses are low.
- R2: A control write (index 0) forms the new status as (value AND enable) OR (old AND NOT enable), with enable = wdata[31:16] and value = wdata[15:0]. Only run (bit 15), pause (bit 14), flush (bit 13), wake (bit 12) and device status (bits 3:0) are writable this way. Dead (bit 11), active (bit 10) and branch-taken (bit 8) are left unchanged even when enabled.
- R3: If wake is set after the merge, active (bit 10) is set.
- R4: If run is set after the merge, active is set and dead is cleared.
- R5: If pause is set after the merge, active is cleared, overriding wake and run.
- R6: A control write that takes run from 1 to 0 clears active and dead. Clearing run when it was already 0 leaves both unchanged.
- R7: If flush is set after the merge, flush_req_o pulses high for exactly one cycle and flush reads back as 0.
- R8: A command-pointer write (index 2) while active is set is ignored and produces no fetch. Otherwise the value is stored with bits 3:0 cleared, and fetch_req_o pulses for one cycle with fetch_addr_o holding the new pointer.
- R9: Reads of the control register (index 0) and of indices 6 and 7 return zero.
- R10: start_req_o pulses for one cycle after every control write whose resulting status has active set.
- R11: Each select register (indices 3, 4, 5) keeps a 4-bit mask from wdata[19:16] and a 4-bit value from wdata[3:0]. It reads back in those positions with all other bits zero and drives sel_mask_o / sel_val_o, 4 bits per register in index order.
- R12: A status write (index 1) replaces the status word with wdata[15:0] directly, with no derived side effects and no pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register word index |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| status_o | output | 16 | Current status word |
| flush_req_o | output | 1 | One-cycle flush request to the peripheral |
| start_req_o | output | 1 | One-cycle start request to the sequencer |
| fetch_req_o | output | 1 | One-cycle descriptor fetch request |
| fetch_addr_o | output | 32 | Command pointer |
| sel_mask_o | output | 12 | Select masks, interrupt/branch/wait |
| sel_val_o | output | 12 | Select values, interrupt/branch/wait |

## Verification
The dead flag is the hardest state to reach: only the descriptor engine sets it, and that engine lies outside this block. The stimulus therefore plants dead (and active) through direct status writes, then shows that run clears dead, that dropping run clears both flags, and that a control write with run already low leaves a planted dead+active pair untouched. Because the pointer guard depends on active, the same planting also sets up the ignored command-pointer write.

// File: rtl/chan_ctrl_pkg.sv
package chan_ctrl_pkg;
  localparam int STAT_W  = 16;
  localparam int B_RUN   = 15;
  localparam int B_PAUSE = 14;
  localparam int B_FLUSH = 13;
  localparam int B_WAKE  = 12;
  localparam int B_DEAD  = 11;
  localparam int B_ACT   = 10;
  localparam int B_BT    = 8;
  localparam int DEV_W   = 4;

  localparam logic [STAT_W-1:0] WR_OK =
    (STAT_W'(1) << B_RUN) | (STAT_W'(1) << B_PAUSE) |
    (STAT_W'(1) << B_FLUSH) | (STAT_W'(1) << B_WAKE) |
    STAT_W'((1 << DEV_W) - 1);

  localparam int IDX_CTRL = 0;
  localparam int IDX_STAT = 1;
  localparam int IDX_PTR  = 2;
  localparam int IDX_SEL0 = 3;
endpackage

// File: rtl/chan_status_next.sv
module chan_status_next
  import chan_ctrl_pkg::*;
(
  input  logic [STAT_W-1:0] old_i,
  input  logic [31:0]       wdata_i,
  output logic [STAT_W-1:0] nxt_o,
  output logic              flush_o
);
  logic [STAT_W-1:0] en, s;

  always_comb begin
    en = wdata_i[31:16] & WR_OK;
    s  = (wdata_i[15:0] & en) | (old_i & ~en);
    if (s[B_WAKE]) s[B_ACT] = 1'b1;
    if (s[B_RUN]) begin
      s[B_ACT]  = 1'b1;
      s[B_DEAD] = 1'b0;
    end
    if (s[B_PAUSE]) s[B_ACT] = 1'b0;
    if (old_i[B_RUN] && !s[B_RUN]) begin
      s[B_ACT]  = 1'b0;
      s[B_DEAD] = 1'b0;
    end
    flush_o    = s[B_FLUSH];
    s[B_FLUSH] = 1'b0;
    nxt_o      = s;
  end
endmodule

// File: rtl/chan_sel_regs.sv
module chan_sel_regs #(
  parameter int NSEL = 3,
  parameter int SW   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NSEL-1:0]   we_i,
  input  logic [SW-1:0]     wmask_i,
  input  logic [SW-1:0]     wval_i,
  output logic [NSEL*SW-1:0] mask_o,
  output logic [NSEL*SW-1:0] val_o
);
  for (genvar g = 0; g < NSEL; g++) begin : g_sel
    logic [SW-1:0] m_q, v_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        m_q <= '0;
        v_q <= '0;
      end else if (we_i[g]) begin
        m_q <= wmask_i;
        v_q <= wval_i;
      end
    end
    assign mask_o[g*SW +: SW] = m_q;
    assign val_o[g*SW +: SW]  = v_q;
  end
endmodule

// File: rtl/chan_ctrl_regs.sv
module chan_ctrl_regs
  import chan_ctrl_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int PTR_W  = 32,
  parameter int NSEL   = 3
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    wr_en_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [31:0]             wdata_i,
  output logic [31:0]             rdata_o,
  output logic [STAT_W-1:0]       status_o,
  output logic                    flush_req_o,
  output logic                    start_req_o,
  output logic                    fetch_req_o,
  output logic [PTR_W-1:0]        fetch_addr_o,
  output logic [NSEL*DEV_W-1:0]   sel_mask_o,
  output logic [NSEL*DEV_W-1:0]   sel_val_o
);
  localparam int ALIGN = 4;

  logic [STAT_W-1:0] stat_q, stat_nxt;
  logic [PTR_W-1:0]  ptr_q;
  logic              flush_hit, flush_q, start_q, fetch_q;
  logic              ctrl_we, stat_we, ptr_we;
  logic [NSEL-1:0]   sel_we;

  assign ctrl_we = wr_en_i && (addr_i == ADDR_W'(IDX_CTRL));
  assign stat_we = wr_en_i && (addr_i == ADDR_W'(IDX_STAT));
  assign ptr_we  = wr_en_i && (addr_i == ADDR_W'(IDX_PTR)) && !stat_q[B_ACT];

  for (genvar g = 0; g < NSEL; g++) begin : g_swe
    assign sel_we[g] = wr_en_i && (addr_i == ADDR_W'(IDX_SEL0 + g));
  end

  chan_status_next u_next (
    .old_i   (stat_q),
    .wdata_i (wdata_i),
    .nxt_o   (stat_nxt),
    .flush_o (flush_hit)
  );

  chan_sel_regs #(.NSEL(NSEL), .SW(DEV_W)) u_sel (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (sel_we),
    .wmask_i (wdata_i[16 +: DEV_W]),
    .wval_i  (wdata_i[0 +: DEV_W]),
    .mask_o  (sel_mask_o),
    .val_o   (sel_val_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q  <= '0;
      ptr_q   <= '0;
      flush_q <= 1'b0;
      start_q <= 1'b0;
      fetch_q <= 1'b0;
    end else begin
      if (ctrl_we)      stat_q <= stat_nxt;
      else if (stat_we) stat_q <= wdata_i[15:0];
      if (ptr_we)       ptr_q  <= {wdata_i[PTR_W-1:ALIGN], {ALIGN{1'b0}}};
      flush_q <= ctrl_we && flush_hit;
      start_q <= ctrl_we && stat_nxt[B_ACT];
      fetch_q <= ptr_we;
    end
  end

  // read mux: control and unmapped indices read zero
  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_W'(IDX_STAT)) rdata_o[STAT_W-1:0] = stat_q;
    if (addr_i == ADDR_W'(IDX_PTR))  rdata_o[PTR_W-1:0]  = ptr_q;
    for (int i = 0; i < NSEL; i++) begin
      if (addr_i == ADDR_W'(IDX_SEL0 + i)) begin
        rdata_o[16 +: DEV_W] = sel_mask_o[i*DEV_W +: DEV_W];
        rdata_o[0 +: DEV_W]  = sel_val_o[i*DEV_W +: DEV_W];
      end
    end
  end

  assign status_o     = stat_q;
  assign flush_req_o  = flush_q;
  assign start_req_o  = start_q;
  assign fetch_req_o  = fetch_q;
  assign fetch_addr_o = ptr_q;
endmodule

// File: rtl/chan_ctrl_regs_chk.sv
module chan_ctrl_regs_chk #(
  parameter int ADDR_W = 3,
  parameter int PTR_W  = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [31:0]       wdata_i,
  input logic [15:0]       status_o,
  input logic              flush_req_o,
  input logic              start_req_o,
  input logic              fetch_req_o,
  input logic [PTR_W-1:0]  fetch_addr_o
);
  logic ctrl_wr, ptr_wr;
  assign ctrl_wr = wr_en_i && (addr_i == ADDR_W'(0));
  assign ptr_wr  = wr_en_i && (addr_i == ADDR_W'(2));

  assert_wake_act_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_wr && wdata_i[28] && wdata_i[12] && wdata_i[30] && !wdata_i[14]
    |=> status_o[10]);

  assert_run_alive_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_wr && wdata_i[31] && wdata_i[15] && wdata_i[30] && !wdata_i[14]
    |=> status_o[10] && !status_o[11]);

  assert_pause_wins_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_wr && wdata_i[30] && wdata_i[14] |=> !status_o[10]);

  assert_run_drop_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_wr && status_o[15] && wdata_i[31] && !wdata_i[15]
    |=> !status_o[10] && !status_o[11]);

  assert_flush_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_req_o |-> !status_o[13]);

  assert_ptr_guard_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_wr && status_o[10] |=> $stable(fetch_addr_o) && !fetch_req_o);

  assert_ptr_align_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_req_o |-> fetch_addr_o[3:0] == 4'h0);

  assert_start_act_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_req_o |-> status_o[10]);
endmodule

bind chan_ctrl_regs chan_ctrl_regs_chk #(.ADDR_W(ADDR_W), .PTR_W(PTR_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .wr_en_i      (wr_en_i),
  .addr_i       (addr_i),
  .wdata_i      (wdata_i),
  .status_o     (status_o),
  .flush_req_o  (flush_req_o),
  .start_req_o  (start_req_o),
  .fetch_req_o  (fetch_req_o),
  .fetch_addr_o (fetch_addr_o)
);

// File: tb/sim_chan_ctrl_regs.sv
module sim_chan_ctrl_regs;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [2:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [15:0] status_o;
  logic        flush_req_o, start_req_o, fetch_req_o;
  logic [31:0] fetch_addr_o;
  logic [11:0] sel_mask_o, sel_val_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  chan_ctrl_regs u0 (.*);

  // {addr, wdata, expected status, expected flush, expected start}
  localparam int NV = 12;
  localparam logic [52:0] VEC [NV] = '{
    {3'd0, 32'h000F_0005, 16'h0005, 1'b0, 1'b0},  // R2 device status
    {3'd0, 32'h0003_000A, 16'h0006, 1'b0, 1'b0},  // R2 partial enable
    {3'd0, 32'h0800_0800, 16'h0006, 1'b0, 1'b0},  // R2 dead not writable
    {3'd0, 32'h1000_1000, 16'h1406, 1'b0, 1'b1},  // R3 wake
    {3'd0, 32'h4000_4000, 16'h5006, 1'b0, 1'b0},  // R5 pause wins
    {3'd0, 32'h5000_0000, 16'h0006, 1'b0, 1'b0},  // R2 clear both
    {3'd1, 32'h0000_0800, 16'h0800, 1'b0, 1'b0},  // R12 plant dead
    {3'd0, 32'h8000_8000, 16'h8400, 1'b0, 1'b1},  // R4 run
    {3'd0, 32'h8000_0000, 16'h0000, 1'b0, 1'b0},  // R6 run drop
    {3'd1, 32'h0000_0C00, 16'h0C00, 1'b0, 1'b0},  // R12 plant dead+active
    {3'd0, 32'h8000_0000, 16'h0C00, 1'b0, 1'b1},  // R6 no transition, R10
    {3'd0, 32'h2000_2000, 16'h0C00, 1'b1, 1'b1}   // R7 flush
  };

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd_chk(input logic [2:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk_i);
    addr_i = a;
    #1 chk(rdata_o, exp, tag);
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    #1;
    chk({16'h0, status_o}, 32'h0, "R1 status");
    chk({29'h0, flush_req_o, start_req_o, fetch_req_o}, 32'h0, "R1 pulses");
    chk(fetch_addr_o, 32'h0, "R1 pointer");
    chk({8'h0, sel_mask_o, sel_val_o}, 32'h0, "R1 select");
    @(negedge clk_i);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][52:50], VEC[i][49:18]);
      chk({16'h0, status_o}, {16'h0, VEC[i][17:2]}, $sformatf("R2-R6/R12 vec%0d status", i));
      chk({31'h0, flush_req_o}, {31'h0, VEC[i][1]}, $sformatf("R7 vec%0d flush", i));
      chk({31'h0, start_req_o}, {31'h0, VEC[i][0]}, $sformatf("R10 vec%0d start", i));
    end
    rd_chk(3'd1, 32'h0000_0C00, "R12 status readback");

    // R7: flush pulse lasts one cycle
    @(negedge clk_i);
    chk({31'h0, flush_req_o}, 32'h0, "R7 pulse width");

    // R9: control and unmapped indices read zero
    rd_chk(3'd0, 32'h0, "R9 control read");
    rd_chk(3'd6, 32'h0, "R9 index 6");
    rd_chk(3'd7, 32'h0, "R9 index 7");

    // R8: pointer write ignored while active
    wr(3'd2, 32'hFFFF_FFF0);
    chk({31'h0, fetch_req_o}, 32'h0, "R8 guarded fetch");
    chk(fetch_addr_o, 32'h0, "R8 guarded value");
    wr(3'd1, 32'h0);
    wr(3'd2, 32'h1234_567F);
    chk({31'h0, fetch_req_o}, 32'h1, "R8 fetch pulse");
    chk(fetch_addr_o, 32'h1234_5670, "R8 aligned pointer");
    rd_chk(3'd2, 32'h1234_5670, "R8 pointer readback");
    chk({31'h0, fetch_req_o}, 32'h0, "R8 fetch pulse width");

    // R11: select registers
    wr(3'd3, 32'hFFFF_FFFF);
    rd_chk(3'd3, 32'h000F_000F, "R11 interrupt select");
    wr(3'd5, 32'h0005_0003);
    rd_chk(3'd5, 32'h0005_0003, "R11 wait select");
    chk({20'h0, sel_mask_o}, 32'h50F, "R11 mask outputs");
    chk({20'h0, sel_val_o}, 32'h30F, "R11 value outputs");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule